// File: doc/BRIEF.md
# Tick Counter Real-Time Clock with Two Compare Alarms

This peripheral keeps time for a chip that has a slow 32768 Hz crystal clock beside its fast bus clock. The crystal clock is brought into the bus domain through a synchroniser, and each rising edge is detected there. A programmable down-counting divider with a half-rate stage turns these edges into counter ticks. With the reset divider value of 1023, the 32-bit tick counter advances 16 times per second. Its four least significant bits are the sixteenths of a second, so shifting the counter right by four gives whole seconds.

Two compare registers hold target counts in tick units. When the counter steps onto a target, a sticky flag sets in the status register. A third flag sets on every whole-second boundary. Each flag has its own enable bit in the same register. The interrupt line is high while any flag is set together with its enable. Software clears a flag by writing 1 to its bit.

Counting runs only while the clock-select field holds the crystal code. A scratch word is reset only by the power-on reset, not by the core reset, so software can keep upper counter bits in it across soft resets.

Top module: `rtc_core`

## Requirements
- R1: After core and power-on reset: counter, alarm0, alarm1, status and clock-select read 0; divider reads 1023; irq is 0.
- R2: The counter advances only while clock-select (offset 0x1C, bits 1:0) holds 3. Any other value freezes the counter, and the written value reads back.
- R3: With clock-select at 3 and divider value D (offset 0x0C), the counter (offset 0x00) rises by exactly one for every 2*(D+1) crystal rising edges, counted from the write that enables it.
- R4: A bus write to the counter loads the written value directly. A read returns the addressed register on rdata in the cycle after the request.
- R5: When the counter steps onto the alarm0 value (offset 0x04), status bit 0 sets. When it steps onto the alarm1 value (offset 0x18), status bit 4 sets.
- R6: Status flag bits 0, 1 and 4 clear when a 1 is written to them, and writing 0 leaves them unchanged.
- R7: Status bits 2 (alarm0 enable), 3 (second enable) and 6 (alarm1 enable) are plain read/write bits.
- R8: Status bit 1 sets whenever the low four counter bits wrap from 15 to 0 on a tick.
- R9: irq is high exactly when one of these pairs is set: bit 0 with bit 2, bit 1 with bit 3, or bit 4 with bit 6. A flag whose enable is clear never raises irq.
- R10: The scratch word (offset 0x40) is read/write. The core reset leaves it unchanged, and only the power-on reset clears it.
- R11: Offsets outside the register set read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the scratch word, active low |
| xtal_clk | input | 1 | 32768 Hz crystal clock, asynchronous to clk |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Interrupt, level high |

## Verification
The alarm and second-boundary flags can only be set by the counter stepping onto a value, and a real 16 Hz rate would take far too long in simulation. The stimulus therefore sets the divider to 0 and preloads the counter one or two ticks below the target, with the low bits at 14 so that a second boundary falls on the same step. It then generates a counted number of crystal pulses by hand. Because the edge count is exact, the counter value and the flag state are known precisely when they are read back. The W1C writes and the enable changes are then checked against irq with the counter frozen.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CMP_A   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIVIDE  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP_B   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_SRC_SEL = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_KEEP    = 8'h40;

    localparam int ST_W      = 7;
    localparam int ST_A_FLG  = 0;
    localparam int ST_S_FLG  = 1;
    localparam int ST_A_EN   = 2;
    localparam int ST_S_EN   = 3;
    localparam int ST_B_FLG  = 4;
    localparam int ST_B_EN   = 6;

    localparam logic [ST_W-1:0] ST_FLAG_MASK = 7'b001_0011;
    localparam logic [ST_W-1:0] ST_EN_MASK   = 7'b100_1100;

    localparam logic [1:0] SRC_XTAL = 2'd3;
endpackage

// File: rtl/rtc_edge_sync.sv
`timescale 1ns/1ps
module rtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             edge_in,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
    } div_t;

    div_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (!run) begin
            d_d.cnt  = reload;
            d_d.half = 1'b0;
        end else if (edge_in) begin
            if (d_q.cnt == '0) begin
                d_d.cnt  = reload;
                d_d.half = ~d_q.half;
            end else begin
                d_d.cnt = d_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign tick = run & edge_in & (d_q.cnt == '0) & d_q.half;
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
    import rtc_pkg::*;
#(
    parameter int                DIV_W       = 16,
    parameter logic [DIV_W-1:0] DIV_RESET   = 16'd1023,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              xtal_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] cmp_a;
        logic [DATA_W-1:0] cmp_b;
        logic [DIV_W-1:0]  div;
        logic [1:0]        src;
        logic [ST_W-1:0]   st;
        logic [DATA_W-1:0] rdata;
    } core_t;

    core_t r_d, r_q;
    logic [DATA_W-1:0] keep_d, keep_q;

    logic xtal_rise;
    logic tick;
    logic running;
    logic wr_req, rd_req;
    logic [DATA_W-1:0] cnt_inc;
    logic [DATA_W-1:0] rd_mux;

    assign running = (r_q.src == SRC_XTAL);
    assign wr_req  = bus_sel & bus_wr;
    assign rd_req  = bus_sel & ~bus_wr;
    assign cnt_inc = r_q.cnt + 1'b1;

    rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (xtal_clk),
        .rise     (xtal_rise)
    );

    rtc_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .edge_in (xtal_rise),
        .reload  (r_q.div),
        .tick    (tick)
    );

    always_comb begin
        case (bus_addr)
            OFS_COUNT:   rd_mux = r_q.cnt;
            OFS_CMP_A:   rd_mux = r_q.cmp_a;
            OFS_STATUS:  rd_mux = DATA_W'(r_q.st);
            OFS_DIVIDE:  rd_mux = DATA_W'(r_q.div);
            OFS_CMP_B:   rd_mux = r_q.cmp_b;
            OFS_SRC_SEL: rd_mux = DATA_W'(r_q.src);
            OFS_KEEP:    rd_mux = keep_q;
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        logic [ST_W-1:0] set_v;
        r_d    = r_q;
        keep_d = keep_q;
        set_v  = '0;

        if (tick) begin
            r_d.cnt = cnt_inc;
            set_v[ST_A_FLG] = (cnt_inc == r_q.cmp_a);
            set_v[ST_B_FLG] = (cnt_inc == r_q.cmp_b);
            set_v[ST_S_FLG] = (r_q.cnt[3:0] == 4'hF);
        end

        if (wr_req) begin
            case (bus_addr)
                OFS_COUNT:   r_d.cnt   = bus_wdata;
                OFS_CMP_A:   r_d.cmp_a = bus_wdata;
                OFS_CMP_B:   r_d.cmp_b = bus_wdata;
                OFS_DIVIDE:  r_d.div   = bus_wdata[DIV_W-1:0];
                OFS_SRC_SEL: r_d.src   = bus_wdata[1:0];
                OFS_KEEP:    keep_d    = bus_wdata;
                OFS_STATUS:  r_d.st    = (bus_wdata[ST_W-1:0] & ST_EN_MASK)
                                       | (r_q.st & ST_FLAG_MASK & ~bus_wdata[ST_W-1:0]);
                default:     ;
            endcase
        end

        r_d.st = r_d.st | set_v;

        if (rd_req) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.div   <= DIV_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) keep_q <= '0;
        else        keep_q <= keep_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq = (r_q.st[ST_A_FLG] & r_q.st[ST_A_EN])
               | (r_q.st[ST_S_FLG] & r_q.st[ST_S_EN])
               | (r_q.st[ST_B_FLG] & r_q.st[ST_B_EN]);
endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              cnt_wr,
    input logic              st_wr,
    input logic              keep_wr,
    input logic              wdata0,
    input logic              tick,
    input logic [1:0]        src,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] cmp_a,
    input logic [ST_W-1:0]   st,
    input logic [DATA_W-1:0] keep
);
    // R2
    frozen_when_other_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_XTAL) |-> !tick);

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt == $past(cnt) + 32'd1));

    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    // R5
    cmp_a_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st[ST_A_FLG]) && !$past(cnt_wr)) |-> (cnt == $past(cmp_a)));

    // R8
    second_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st[ST_S_FLG]) && !$past(cnt_wr)) |-> (cnt[3:0] == 4'h0));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wdata0 && !tick) |=> !st[ST_A_FLG]);

    // R10
    keep_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !keep_wr |=> $stable(keep));
endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_n   (por_n),
    .cnt_wr  (wr_req && (bus_addr == rtc_pkg::OFS_COUNT)),
    .st_wr   (wr_req && (bus_addr == rtc_pkg::OFS_STATUS)),
    .keep_wr (wr_req && (bus_addr == rtc_pkg::OFS_KEEP)),
    .wdata0  (bus_wdata[0]),
    .tick    (tick),
    .src     (r_q.src),
    .cnt     (r_q.cnt),
    .cmp_a   (r_q.cmp_a),
    .st      (r_q.st),
    .keep    (keep_q)
);

// File: tb/tb_rtc_core.sv
`timescale 1ns/1ps
module tb_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        xtal_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rtc_core dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .xtal_clk(xtal_clk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] reload;
        logic [15:0] pulses;
        logic [31:0] exp_cnt;
        logic        exp_sec;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{16'd0, 16'd8,  32'd4,  1'b0},
        '{16'd1, 16'd8,  32'd2,  1'b0},
        '{16'd2, 16'd13, 32'd2,  1'b0},
        '{16'd3, 16'd17, 32'd2,  1'b0},
        '{16'd0, 16'd34, 32'd17, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic xpulses(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (3) @(negedge clk);
            xtal_clk = 1'b1;
            repeat (3) @(negedge clk);
            xtal_clk = 1'b0;
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bread(8'h00, rd); chk("R1 counter", rd, 32'h0);
        bread(8'h04, rd); chk("R1 alarm0", rd, 32'h0);
        bread(8'h18, rd); chk("R1 alarm1", rd, 32'h0);
        bread(8'h08, rd); chk("R1 status", rd, 32'h0);
        bread(8'h0C, rd); chk("R1 divider", rd, 32'd1023);
        bread(8'h1C, rd); chk("R1 clksel", rd, 32'h0);
        bread(8'h40, rd); chk("R1 scratch", rd, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R3 / R8 table of divider settings and pulse counts
        for (int v = 0; v < NV; v++) begin
            bwrite(8'h1C, 32'h0);
            bwrite(8'h00, 32'h0);
            bwrite(8'h0C, {16'h0, VEC[v].reload});
            bwrite(8'h08, 32'h13);
            bwrite(8'h1C, 32'h3);
            xpulses(int'(VEC[v].pulses));
            bread(8'h00, rd); chk($sformatf("R3 vector %0d count", v), rd, VEC[v].exp_cnt);
            bread(8'h08, rd);
            chk($sformatf("R8 vector %0d second flag", v), rd & 32'h2, {30'h0, VEC[v].exp_sec, 1'b0});
        end

        // R2 other source code freezes counter, reads back
        bwrite(8'h1C, 32'h2);
        bread(8'h1C, rd); chk("R2 clksel readback", rd, 32'h2);
        bread(8'h00, rd);
        xpulses(10);
        begin
            logic [31:0] rd2;
            bread(8'h00, rd2); chk("R2 frozen counter", rd2, rd);
        end

        // R4 direct load
        bwrite(8'h00, 32'hDEAD_BEE0);
        bread(8'h00, rd); chk("R4 counter load", rd, 32'hDEAD_BEE0);

        // R5 / R8 / R9 alarm0 with second wrap on same step
        bwrite(8'h0C, 32'h0);
        bwrite(8'h00, 32'h0E);
        bwrite(8'h04, 32'h10);
        bwrite(8'h08, 32'h04);
        bwrite(8'h1C, 32'h3);
        xpulses(4);
        bwrite(8'h1C, 32'h0);
        bread(8'h00, rd); chk("R5 counter at alarm0", rd, 32'h10);
        bread(8'h08, rd); chk("R5 R8 status after alarm0", rd, 32'h07);
        chk("R9 irq alarm0 enabled", {31'h0, irq}, 32'h1);

        // R6 writing zeros keeps flags
        bwrite(8'h08, 32'h04);
        bread(8'h08, rd); chk("R6 zero write keeps flags", rd, 32'h07);
        bwrite(8'h08, 32'h05);
        bread(8'h08, rd); chk("R6 w1c alarm0", rd, 32'h06);
        chk("R9 irq low, second flag not enabled", {31'h0, irq}, 32'h0);

        // R7 enable bits read/write, R9 second enable
        bwrite(8'h08, 32'h08);
        bread(8'h08, rd); chk("R7 enables rewritten", rd, 32'h0A);
        chk("R9 irq second enabled", {31'h0, irq}, 32'h1);
        bwrite(8'h08, 32'h0A);
        bread(8'h08, rd); chk("R6 w1c second flag", rd, 32'h08);
        chk("R9 irq after clear", {31'h0, irq}, 32'h0);

        // R5 alarm1
        bwrite(8'h00, 32'h20);
        bwrite(8'h18, 32'h21);
        bwrite(8'h08, 32'h40);
        bwrite(8'h1C, 32'h3);
        xpulses(2);
        bwrite(8'h1C, 32'h0);
        bread(8'h08, rd); chk("R5 alarm1 flag", rd, 32'h50);
        chk("R9 irq alarm1", {31'h0, irq}, 32'h1);
        bwrite(8'h08, 32'h50);
        bread(8'h08, rd); chk("R6 w1c alarm1", rd, 32'h40);
        chk("R9 irq alarm1 cleared", {31'h0, irq}, 32'h0);

        // R9 flag without enable
        bwrite(8'h04, 32'h22);
        bwrite(8'h08, 32'h00);
        bwrite(8'h1C, 32'h3);
        xpulses(2);
        bwrite(8'h1C, 32'h0);
        bread(8'h08, rd); chk("R5 alarm0 flag without enable", rd, 32'h01);
        chk("R9 irq stays low without enable", {31'h0, irq}, 32'h0);

        // R11 unmapped offset
        bwrite(8'h10, 32'hFFFF_FFFF);
        bread(8'h10, rd); chk("R11 unmapped reads zero", rd, 32'h0);
        bread(8'h04, rd); chk("R11 alarm0 untouched", rd, 32'h22);

        // R10 scratch across core reset
        bwrite(8'h40, 32'hA5A5_1234);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bread(8'h40, rd); chk("R10 scratch kept", rd, 32'hA5A5_1234);
        bread(8'h00, rd); chk("R1 counter after core reset", rd, 32'h0);
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        bread(8'h40, rd); chk("R10 scratch cleared by por", rd, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule